// File: doc/BRIEF.md
# Multi-Standard YCbCr to RGB Converter

This block turns one studio-range YCbCr pixel per clock into a full-range RGB pixel. Each pixel arrives with a two-bit standard selector. The selector picks one of three built-in coefficient sets, or a user-supplied set of four gains that is presented on dedicated inputs. The user set lets an integrator program a custom colour matrix without any divider in hardware.

The datapath first subtracts the black-level offset from luma and the mid-scale offset from both chroma samples. It then stretches luma by (2^W−1)/(219·2^(W−8)) and chroma by (2^W−1)/(224·2^(W−8)). Red and blue are each rebuilt with one gain multiply. Green is rebuilt from two weighted chroma terms, so the datapath uses four multipliers in all. Each channel is rounded to the nearest code and saturated into 0..2^W−1. A valid flag travels with the data through four register stages.

Top module: `ycc2rgb_conv`

## Requirements
- R1: A pixel sampled with `in_valid` high at rising edge t appears on the outputs after edge t+3, with `out_valid` high. `out_valid` repeats the `in_valid` pattern four edges later, idle cycles included.
- R2: While `rst_n` is low, `out_valid` is 0 and all three colour outputs are 0.
- R3: A channel whose rounded result is above 2^W−1 outputs exactly 2^W−1 and does not wrap. Example at W=8 and BT.601: Y=255, Cr=255 gives R=255.
- R4: A channel whose rounded result is below 0 outputs exactly 0. Example at W=8: Y=0, Cb=0 gives B=0.
- R5: With Cb=Cr=128·2^(W−8), all three outputs are equal to round((Y−16·2^(W−8))·(2^W−1)/(219·2^(W−8))), clamped. Y=16 gives 0 and Y=235 gives 255 at W=8.
- R6: `std_sel` encoding: 0 selects ka=0.299, kb=0.114. 1 selects ka=0.2126, kb=0.0722. 2 selects ka=0.2627, kb=0.0593. 3 selects the user gains.
- R7: With EY=(Y−16s)/(219s), Pb=(Cb−128s)/(224s), Pr=(Cr−128s)/(224s) and s=2^(W−8): R = EY + 2(1−ka)·Pr and B = EY + 2(1−kb)·Pb. Each output equals round((2^W−1)·E) within ±1 code.
- R8: G = EY − [ka·2(1−ka)·Pr + kb·2(1−kb)·Pb]/(1−ka−kb), quantized like R7 and accurate within ±1 code.
- R9: In user mode the four gain inputs are unsigned fixed point with 14 fraction bits (value = code/16384). They take the place of the red gain 2(1−ka), the blue gain 2(1−kb) and the two green weights.
- R10: The selector and the user gains are sampled together with each pixel. A change between back-to-back pixels affects only the pixels sampled after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| std_sel | input | 2 | Coefficient set select (R6) |
| y_in | input | W | Luma sample |
| cb_in | input | W | Blue-difference chroma sample |
| cr_in | input | W | Red-difference chroma sample |
| usr_red_gain | input | 16 | User red gain, Q2.14 |
| usr_blue_gain | input | 16 | User blue gain, Q2.14 |
| usr_green_cr_wt | input | 16 | User green weight on Cr, Q2.14 |
| usr_green_cb_wt | input | 16 | User green weight on Cb, Q2.14 |
| out_valid | output | 1 | Output pixel qualifier |
| r_out | output | W | Red code |
| g_out | output | W | Green code |
| b_out | output | W | Blue code |

## Verification
A change of standard and a saturating channel can both land on the same pixel. The selector then has to follow that pixel through the pipeline while the clamp acts on a result produced with the new gains. The bench provokes this by switching `std_sel` on back-to-back pixels with extreme chroma, and by sweeping a coarse Y/Cb/Cr grid under all four selections with idle cycles mixed in. Each output is judged against a real-valued model of the conversion equations and checked against the issue cycle of its pixel.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

  localparam int GAIN_FRAC = 14;
  localparam int GAIN_W    = GAIN_FRAC + 2;

  typedef enum logic [1:0] {
    STD_BT601  = 2'd0,
    STD_BT709  = 2'd1,
    STD_BT2020 = 2'd2,
    STD_USER   = 2'd3
  } cs_std_e;

  typedef struct packed {
    logic [GAIN_W-1:0] red_gain;
    logic [GAIN_W-1:0] blue_gain;
    logic [GAIN_W-1:0] green_cr_wt;
    logic [GAIN_W-1:0] green_cb_wt;
  } gain_set_t;

  // millionths -> unsigned fixed point with GAIN_FRAC fraction bits
  function automatic logic [GAIN_W-1:0] micro_to_q(input longint micro);
    longint t;
    t = (micro * (longint'(1) <<< GAIN_FRAC) + 64'sd500000) / 64'sd1000000;
    return t[GAIN_W-1:0];
  endfunction

  // rounded (2^w-1)*2^frac / (levels*2^(w-8))
  function automatic longint range_gain(input int w, input int frac, input int levels);
    longint num;
    longint den;
    num = ((longint'(1) <<< w) - 1) <<< frac;
    den = longint'(levels) * (longint'(1) <<< (w - 8));
    return (2 * num + den) / (2 * den);
  endfunction

  function automatic gain_set_t builtin_gains(input cs_std_e s);
    gain_set_t g;
    case (s)
      STD_BT709: begin
        g.red_gain    = micro_to_q(1574800);
        g.blue_gain   = micro_to_q(1855600);
        g.green_cr_wt = micro_to_q(468124);
        g.green_cb_wt = micro_to_q(187324);
      end
      STD_BT2020: begin
        g.red_gain    = micro_to_q(1474600);
        g.blue_gain   = micro_to_q(1881400);
        g.green_cr_wt = micro_to_q(571353);
        g.green_cb_wt = micro_to_q(164553);
      end
      default: begin
        g.red_gain    = micro_to_q(1402000);
        g.blue_gain   = micro_to_q(1772000);
        g.green_cr_wt = micro_to_q(714136);
        g.green_cb_wt = micro_to_q(344136);
      end
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ycc2rgb_coef_sel.sv
module ycc2rgb_coef_sel
  import ycc2rgb_pkg::*;
(
  input  logic [1:0] sel,
  input  gain_set_t  user_gains,
  output gain_set_t  gains
);

  cs_std_e sel_e;
  assign sel_e = cs_std_e'(sel);

  always_comb begin
    if (sel_e == STD_USER) gains = user_gains;
    else                   gains = builtin_gains(sel_e);
  end

endmodule

// File: rtl/ycc2rgb_prescale.sv
module ycc2rgb_prescale
  import ycc2rgb_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = W + 2,
  parameter int PW = DW + GAIN_FRAC + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         y_i,
  input  logic [W-1:0]         cb_i,
  input  logic [W-1:0]         cr_i,
  input  gain_set_t            gains_i,
  output logic signed [PW-1:0] ys_o,
  output logic signed [PW-1:0] cbs_o,
  output logic signed [PW-1:0] crs_o,
  output gain_set_t            gains_o
);

  localparam int KW = GAIN_FRAC + 2;
  localparam longint KY_L = range_gain(W, GAIN_FRAC, 219);
  localparam longint KC_L = range_gain(W, GAIN_FRAC, 224);
  localparam logic signed [KW:0] KY = (KW+1)'(KY_L);
  localparam logic signed [KW:0] KC = (KW+1)'(KC_L);
  localparam int OFS_Y = 16 << (W - 8);
  localparam int OFS_C = 128 << (W - 8);

  logic signed [DW-1:0] yd_c, cbd_c, crd_c;
  logic signed [DW-1:0] yd_q, cbd_q, crd_q;
  gain_set_t            g1_q;

  assign yd_c  = DW'(y_i)  - DW'(OFS_Y);
  assign cbd_c = DW'(cb_i) - DW'(OFS_C);
  assign crd_c = DW'(cr_i) - DW'(OFS_C);

  // stage 1: offset removal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yd_q  <= '0;
      cbd_q <= '0;
      crd_q <= '0;
      g1_q  <= '0;
    end else begin
      yd_q  <= yd_c;
      cbd_q <= cbd_c;
      crd_q <= crd_c;
      g1_q  <= gains_i;
    end
  end

  // stage 2: range stretch into output-code units with GAIN_FRAC fraction bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ys_o    <= '0;
      cbs_o   <= '0;
      crs_o   <= '0;
      gains_o <= '0;
    end else begin
      ys_o    <= PW'(yd_q)  * PW'(KY);
      cbs_o   <= PW'(cbd_q) * PW'(KC);
      crs_o   <= PW'(crd_q) * PW'(KC);
      gains_o <= g1_q;
    end
  end

endmodule

// File: rtl/ycc2rgb_mult4.sv
module ycc2rgb_mult4
  import ycc2rgb_pkg::*;
#(
  parameter int PW = 27,
  parameter int MW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] ys_i,
  input  logic signed [PW-1:0] cbs_i,
  input  logic signed [PW-1:0] crs_i,
  input  gain_set_t            gains_i,
  output logic signed [PW-1:0] ys_o,
  output logic signed [MW-1:0] p_red_o,
  output logic signed [MW-1:0] p_blue_o,
  output logic signed [MW-1:0] p_gcr_o,
  output logic signed [MW-1:0] p_gcb_o
);

  localparam int NPROD = 4;
  localparam int XW    = PW + GAIN_W + 1;

  logic [GAIN_W-1:0]    gain_arr [NPROD];
  logic signed [MW-1:0] prod_q   [NPROD];

  // product order: red, blue, green-Cr, green-Cb (odd slots use Cb)
  assign gain_arr[0] = gains_i.red_gain;
  assign gain_arr[1] = gains_i.blue_gain;
  assign gain_arr[2] = gains_i.green_cr_wt;
  assign gain_arr[3] = gains_i.green_cb_wt;

  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    logic signed [PW-1:0]   opnd;
    logic signed [GAIN_W:0] gs;
    logic signed [XW-1:0]   full;
    assign opnd = (k % 2 == 1) ? cbs_i : crs_i;
    assign gs   = $signed({1'b0, gain_arr[k]});
    assign full = XW'(opnd) * XW'(gs);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[k] <= '0;
      else        prod_q[k] <= MW'(full >>> GAIN_FRAC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ys_o <= '0;
    else        ys_o <= ys_i;
  end

  assign p_red_o  = prod_q[0];
  assign p_blue_o = prod_q[1];
  assign p_gcr_o  = prod_q[2];
  assign p_gcb_o  = prod_q[3];

endmodule

// File: rtl/ycc2rgb_recon.sv
module ycc2rgb_recon
  import ycc2rgb_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = 27,
  parameter int MW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] ys_i,
  input  logic signed [MW-1:0] p_red_i,
  input  logic signed [MW-1:0] p_blue_i,
  input  logic signed [MW-1:0] p_gcr_i,
  input  logic signed [MW-1:0] p_gcb_i,
  output logic [W-1:0]         r_o,
  output logic [W-1:0]         g_o,
  output logic [W-1:0]         b_o,
  output logic [2:0]           ovf_o,
  output logic [2:0]           unf_o
);

  localparam int NCH  = 3;
  localparam int SW   = MW + 2;
  localparam int HALF = 1 << (GAIN_FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((longint'(1) <<< W) - 1);

  logic signed [SW-1:0] sum_c [NCH];
  logic [W-1:0]         ch_q  [NCH];

  always_comb begin
    sum_c[0] = SW'(ys_i) + SW'(p_red_i);
    sum_c[1] = SW'(ys_i) - SW'(p_gcr_i) - SW'(p_gcb_i);
    sum_c[2] = SW'(ys_i) + SW'(p_blue_i);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SW-1:0] rnd;
    logic [W-1:0]         sat;
    assign rnd      = (sum_c[c] + SW'(HALF)) >>> GAIN_FRAC;
    assign ovf_o[c] = (rnd > MAXV);
    assign unf_o[c] = (rnd < 0);
    always_comb begin
      if (ovf_o[c])      sat = '1;
      else if (unf_o[c]) sat = '0;
      else               sat = rnd[W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q[c] <= '0;
      else        ch_q[c] <= sat;
    end
  end

  assign r_o = ch_q[0];
  assign g_o = ch_q[1];
  assign b_o = ch_q[2];

endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
  import ycc2rgb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        std_sel,
  input  logic [W-1:0]      y_in,
  input  logic [W-1:0]      cb_in,
  input  logic [W-1:0]      cr_in,
  input  logic [GAIN_W-1:0] usr_red_gain,
  input  logic [GAIN_W-1:0] usr_blue_gain,
  input  logic [GAIN_W-1:0] usr_green_cr_wt,
  input  logic [GAIN_W-1:0] usr_green_cb_wt,
  output logic              out_valid,
  output logic [W-1:0]      r_out,
  output logic [W-1:0]      g_out,
  output logic [W-1:0]      b_out
);

  localparam int LAT = 4;
  localparam int DW  = W + 2;
  localparam int PW  = DW + GAIN_FRAC + 3;
  localparam int MW  = PW + 2;

  gain_set_t usr_g, sel_g, g2;
  logic signed [PW-1:0] ys2, cbs2, crs2, ys3;
  logic signed [MW-1:0] p_red, p_blue, p_gcr, p_gcb;
  logic [LAT-1:0] vpipe;

  // named events for the checker
  logic       st3_valid;
  logic [2:0] ovf_flags;
  logic [2:0] unf_flags;

  always_comb begin
    usr_g.red_gain    = usr_red_gain;
    usr_g.blue_gain   = usr_blue_gain;
    usr_g.green_cr_wt = usr_green_cr_wt;
    usr_g.green_cb_wt = usr_green_cb_wt;
  end

  ycc2rgb_coef_sel u_sel (
    .sel        (std_sel),
    .user_gains (usr_g),
    .gains      (sel_g)
  );

  ycc2rgb_prescale #(.W(W), .DW(DW), .PW(PW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .y_i     (y_in),
    .cb_i    (cb_in),
    .cr_i    (cr_in),
    .gains_i (sel_g),
    .ys_o    (ys2),
    .cbs_o   (cbs2),
    .crs_o   (crs2),
    .gains_o (g2)
  );

  ycc2rgb_mult4 #(.PW(PW), .MW(MW)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .ys_i     (ys2),
    .cbs_i    (cbs2),
    .crs_i    (crs2),
    .gains_i  (g2),
    .ys_o     (ys3),
    .p_red_o  (p_red),
    .p_blue_o (p_blue),
    .p_gcr_o  (p_gcr),
    .p_gcb_o  (p_gcb)
  );

  ycc2rgb_recon #(.W(W), .PW(PW), .MW(MW)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ys_i     (ys3),
    .p_red_i  (p_red),
    .p_blue_i (p_blue),
    .p_gcr_i  (p_gcr),
    .p_gcb_i  (p_gcb),
    .r_o      (r_out),
    .g_o      (g_out),
    .b_o      (b_out),
    .ovf_o    (ovf_flags),
    .unf_o    (unf_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];
  assign st3_valid = vpipe[LAT-2];

endmodule

// File: rtl/ycc2rgb_conv_chk.sv
module ycc2rgb_conv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] cb_in,
  input logic [W-1:0] cr_in,
  input logic         out_valid,
  input logic [W-1:0] r_out,
  input logic [W-1:0] g_out,
  input logic [W-1:0] b_out,
  input logic         st3_valid,
  input logic [2:0]   ovf_flags,
  input logic [2:0]   unf_flags
);

  localparam logic [W-1:0] MAXC = '1;
  localparam logic [W-1:0] MIDC = W'(128 << (W - 8));

  logic [3:0] vhist;
  logic [3:0] nhist;
  logic       neutral;

  assign neutral = in_valid && (cb_in == MIDC) && (cr_in == MIDC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vhist <= '0;
      nhist <= '0;
    end else begin
      vhist <= {vhist[2:0], in_valid};
      nhist <= {nhist[2:0], neutral};
    end
  end

  // R1: output qualifier follows the input qualifier four edges later
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[3]);

  // R3: saturation high on red and blue
  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st3_valid && ovf_flags[0]) |=> (r_out == MAXC));
  p_clamp_hi_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st3_valid && ovf_flags[2]) |=> (b_out == MAXC));

  // R4: saturation low on blue and green
  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st3_valid && unf_flags[2]) |=> (b_out == '0));
  p_clamp_lo_g_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st3_valid && unf_flags[1]) |=> (g_out == '0));

  // R5: neutral chroma yields a grey pixel
  p_gray_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nhist[3]) |-> (r_out == g_out && g_out == b_out));

  // R2: quiet outputs while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r2: assert (!out_valid && r_out == '0 && g_out == '0 && b_out == '0);
    end
  end

endmodule

bind ycc2rgb_conv ycc2rgb_conv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .cb_in     (cb_in),
  .cr_in     (cr_in),
  .out_valid (out_valid),
  .r_out     (r_out),
  .g_out     (g_out),
  .b_out     (b_out),
  .st3_valid (st3_valid),
  .ovf_flags (ovf_flags),
  .unf_flags (unf_flags)
);

// File: tb/ycc2rgb_conv_test.sv
module ycc2rgb_conv_test;

  localparam int  W      = 8;
  localparam int  MAXI   = (1 << W) - 1;
  localparam real CLK_NS = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] std_sel = 2'd0;
  logic [W-1:0] y_in = '0, cb_in = '0, cr_in = '0;
  logic [15:0] usr_red_gain = '0, usr_blue_gain = '0, usr_green_cr_wt = '0, usr_green_cb_wt = '0;
  logic out_valid;
  logic [W-1:0] r_out, g_out, b_out;

  always #(CLK_NS/2) clk = ~clk;

  ycc2rgb_conv #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .std_sel(std_sel),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .usr_red_gain(usr_red_gain), .usr_blue_gain(usr_blue_gain),
    .usr_green_cr_wt(usr_green_cr_wt), .usr_green_cb_wt(usr_green_cb_wt),
    .out_valid(out_valid), .r_out(r_out), .g_out(g_out), .b_out(b_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n_issued = 0;
  int n_seen   = 0;

  // custom matrix used for the user-gain mode
  real u_ka = 0.25;
  real u_kb = 0.10;

  typedef struct {
    int    er, eg, eb;
    int    tol;
    int    issue;
    string tag_rb;
    string tag_g;
  } exp_t;
  exp_t expq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    n_tests++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  function automatic int to_code(input real e);
    real v;
    v = e * MAXI;
    if (v < 0.0) return 0;
    if (v > MAXI) return MAXI;
    return $rtoi(v + 0.5);
  endfunction

  function automatic void std_k(input int sel, output real ka, output real kb);
    case (sel)
      0: begin ka = 0.299;  kb = 0.114;  end
      1: begin ka = 0.2126; kb = 0.0722; end
      2: begin ka = 0.2627; kb = 0.0593; end
      default: begin ka = u_ka; kb = u_kb; end
    endcase
  endfunction

  function automatic logic [15:0] qgain(input real v);
    return 16'($rtoi(v * 16384.0 + 0.5));
  endfunction

  // drive one pixel and queue its expected result
  task automatic issue(input int sel, input int y, input int cb, input int cr,
                       input int tol, input string trb, input string tg);
    real ka, kb, s, ey, pb, pr, rr, gg, bb;
    exp_t e;
    @(negedge clk);
    std_sel = 2'(sel);
    y_in = W'(y); cb_in = W'(cb); cr_in = W'(cr);
    in_valid = 1'b1;
    std_k(sel, ka, kb);
    s  = real'(1 << (W - 8));
    ey = (y - 16.0 * s) / (219.0 * s);
    pb = (cb - 128.0 * s) / (224.0 * s);
    pr = (cr - 128.0 * s) / (224.0 * s);
    rr = ey + 2.0 * (1.0 - ka) * pr;
    bb = ey + 2.0 * (1.0 - kb) * pb;
    gg = ey - (ka * 2.0 * (1.0 - ka) * pr + kb * 2.0 * (1.0 - kb) * pb) / (1.0 - ka - kb);
    e.er = to_code(rr); e.eg = to_code(gg); e.eb = to_code(bb);
    e.tol = tol; e.issue = cyc; e.tag_rb = trb; e.tag_g = tg;
    expq.push_back(e);
    n_issued++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    y_in = 8'hA5; cb_in = 8'h11; cr_in = 8'hEE;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1: actual unexpected out_valid expected none");
      end else begin
        exp_t e;
        e = expq.pop_front();
        n_seen++;
        check({"R1 latency"}, cyc - e.issue, 4, 0);
        check({e.tag_rb, " red"},  int'(r_out), e.er, e.tol);
        check({e.tag_rb, " blue"}, int'(b_out), e.eb, e.tol);
        check({e.tag_g,  " green"}, int'(g_out), e.eg, e.tol);
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int gap;
    usr_red_gain    = qgain(2.0 * (1.0 - u_ka));
    usr_blue_gain   = qgain(2.0 * (1.0 - u_kb));
    usr_green_cr_wt = qgain(u_ka * 2.0 * (1.0 - u_ka) / (1.0 - u_ka - u_kb));
    usr_green_cb_wt = qgain(u_kb * 2.0 * (1.0 - u_kb) / (1.0 - u_ka - u_kb));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    check("R2 out_valid", int'(out_valid), 0, 0);
    check("R2 rgb zero", int'(r_out) + int'(g_out) + int'(b_out), 0, 0);
    rst_n = 1'b1;

    // R5: neutral chroma, exact black and white
    issue(0, 16, 128, 128, 0, "R5", "R5");
    issue(1, 235, 128, 128, 0, "R5", "R5");
    issue(2, 126, 128, 128, 1, "R5", "R5");
    // R3 / R4: saturation corners, exact
    issue(0, 255, 128, 255, 0, "R3", "R3");
    issue(1, 255, 255, 255, 0, "R3", "R3");
    issue(0, 0, 0, 128, 0, "R4", "R4");
    issue(2, 0, 0, 0, 0, "R4", "R4");
    idle();

    // R6/R7/R8/R9 sweep with idle bubbles (R1)
    gap = 0;
    for (int sel = 0; sel < 4; sel++) begin
      for (int yi = 0; yi < 256; yi += 17) begin
        for (int bi = 0; bi < 256; bi += 17) begin
          for (int ri = 0; ri < 256; ri += 17) begin
            if (sel == 3) issue(sel, yi, bi, ri, 1, "R9 R7", "R9 R8");
            else          issue(sel, yi, bi, ri, 1, "R6 R7", "R6 R8");
            gap++;
            if (gap % 7 == 0) idle();
          end
        end
      end
    end

    // R10: selector changes on back-to-back pixels, with saturating chroma
    for (int k = 0; k < 12; k++) begin
      issue(k % 4, 128, 40 + 15 * k, 230 - 10 * k, 1, "R10", "R10");
    end
    for (int k = 0; k < 8; k++) begin
      issue((3 * k) % 4, 240, 250, 10, 1, "R10", "R10");
    end
    idle();

    for (int w = 0; w < 20 && expq.size() != 0; w++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R1 output count", n_seen, n_issued, 0);
    check("R1 valid low after drain", int'(out_valid), 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule